// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block decides, for every decoded command of a serial flash device, whether the command may go ahead. It owns the protection-related part of the status register: the write-enable latch, a block-protect field and a status-lock bit. It also watches an active-low write-protect pin, which passes through a synchronizer before use. Enable, disable, status-write, page-program, sector-erase and bulk-erase strobes arrive as single-cycle pulses. The block answers each one with a one-cycle accept or reject pulse and updates its register in the same cycle.

The block-protect field picks a protected area at the top of the sector space. Program and erase requests that fall inside this area are refused. When the status-lock bit is set and the synchronized pin is low, the device is in hardware-locked mode, and no status write can change the protection settings until the pin goes high again. The surrounding serial interface, the opcode decoder and the array controller use the accept pulse to carry the command out and the reject pulse to drop it.

Top module: `flash_wprot`

## Requirements
- R1: After reset the status byte reads 0x00, `hw_locked` is 0 and neither answer pulse is active.
- R2: An enable strobe sets the write-enable latch (status bit 1) and is accepted. A disable strobe clears the latch and is accepted.
- R3: With the status-lock bit clear, a status write issued while the latch is set is accepted at either pin level. It loads the lock bit from data bit 7 and the block-protect field from data bits 4:2, then clears the latch. The lock bit and the protect field change only in a cycle whose answer is an accept.
- R4: With the lock bit set and the pin high, a status write issued while the latch is set is accepted and loads the register as in R3.
- R5: With the lock bit set and the synchronized pin low, every status write is rejected. The lock bit and the protect field keep their values, and the latch is cleared.
- R6: `hw_locked` is 1 exactly when the lock bit is set and the synchronized pin is low. The two conditions may arise in either order. A pin change reaches `hw_locked` within three clock cycles, and driving the pin high is what releases the lock.
- R7: A status-write, program or erase strobe issued while the latch is clear is rejected and changes nothing in the status byte.
- R8: With a protect value n other than 0, the protected area is the top 2^(n-1) of the 128 sectors, and the sector index is cmd_addr[22:16]. A page program or sector erase inside that area is rejected and clears the latch.
- R9: With the latch set, a page program or sector erase outside the protected area (including any address when n is 0) is accepted and clears the latch.
- R10: A bulk erase is rejected when any protect bit is set, and the latch is then cleared. With the protect field at 0 and the latch set, it is accepted and clears the latch.
- R11: Each strobe yields exactly one of `cmd_ok` or `cmd_nok`, high for the single cycle after the strobe. No answer pulse appears in a cycle that follows no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_pin | input | 1 | Write-protect pin, low requests protection, asynchronous |
| stb_wren | input | 1 | Write-enable command strobe |
| stb_wrdi | input | 1 | Write-disable command strobe |
| stb_wrsr | input | 1 | Status-write command strobe |
| stb_prog | input | 1 | Page-program command strobe |
| stb_serase | input | 1 | Sector-erase command strobe |
| stb_berase | input | 1 | Bulk-erase command strobe |
| wrsr_byte | input | 8 | Data byte of a status write |
| cmd_addr | input | 23 | Byte address of a program or sector erase |
| cmd_ok | output | 1 | Command accepted, one-cycle pulse |
| cmd_nok | output | 1 | Command rejected, one-cycle pulse |
| status_q | output | 8 | Status byte: bit 7 lock, bits 4:2 protect field, bit 1 latch |
| hw_locked | output | 1 | Hardware-locked mode indicator |

## Verification
The assertions assume that the decoder raises at most one command strobe in any cycle. Under that condition every answer can be traced to a single command kind. The directed stimulus drives each strobe alone for one cycle, starting at a falling edge, and waits three cycles after each pin change so that the synchronized level has settled before the next command. Address and data inputs only change together with a strobe. As a result, the checks on protected areas and on the locked mode never depend on a pin transition that is still in flight.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

   localparam int SR_W     = 8;
   localparam int SR_WEL   = 1;
   localparam int SR_BP_LO = 2;
   localparam int SR_LOCK  = 7;

   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_WREN  = 3'd1,
      K_WRDI  = 3'd2,
      K_WRSR  = 3'd3,
      K_PROG  = 3'd4,
      K_SERA  = 3'd5,
      K_BERA  = 3'd6
   } cmd_kind_t;

   typedef struct packed {
      logic ok;
      logic nok;
      logic wel_nx;
      logic sr_load;
   } verdict_t;

endpackage

// File: rtl/wpg_pin_sync.sv
module wpg_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wpg_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q[gi] <= RST_VAL;
            end else if (gi == 0) begin
               chain_q[gi] <= pin_async;
            end else begin
               chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi-1];
            end
         end
      end
   endgenerate

   assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/wpg_area_check.sv
module wpg_area_check #(
   parameter int ADDR_W = 23,
   parameter int SECT_W = 7,
   parameter int BP_W   = 3
) (
   input  logic [BP_W-1:0]   bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              bp_any,
   output logic              in_area
);

   localparam int NUM_SECT = 1 << SECT_W;
   localparam int MAX_SHIFT = (1 << BP_W) - 2;

   generate
      if (SECT_W > ADDR_W) begin : g_bad_sect
         $error("wpg_area_check: SECT_W exceeds ADDR_W");
      end
      if (MAX_SHIFT > SECT_W) begin : g_bad_bp
         $error("wpg_area_check: largest protected area exceeds sector count");
      end
   endgenerate

   logic [SECT_W-1:0] sect_idx;
   logic [SECT_W:0]   area_size;
   logic [SECT_W:0]   area_base;
   logic [BP_W-1:0]   shift_amt;

   assign sect_idx = addr[ADDR_W-1 -: SECT_W];
   assign bp_any   = |bp;

   generate
      if (ADDR_W > SECT_W) begin : g_low_bits
         logic unused_low;
         assign unused_low = ^addr[ADDR_W-SECT_W-1:0];
      end
   endgenerate

   always_comb begin
      shift_amt = bp_any ? (bp - BP_W'(1)) : '0;
      area_size = (SECT_W+1)'(1) << shift_amt;
      area_base = (SECT_W+1)'(NUM_SECT) - area_size;
      in_area   = bp_any && ({1'b0, sect_idx} >= area_base);
   end

endmodule

// File: rtl/wpg_judge.sv
module wpg_judge
   import wpg_pkg::*;
(
   input  cmd_kind_t kind,
   input  logic      wel,
   input  logic      locked,
   input  logic      in_area,
   input  logic      bp_any,
   output verdict_t  verdict
);

   always_comb begin
      verdict = '{ok: 1'b0, nok: 1'b0, wel_nx: wel, sr_load: 1'b0};
      unique case (kind)
         K_WREN: begin
            verdict.ok     = 1'b1;
            verdict.wel_nx = 1'b1;
         end
         K_WRDI: begin
            verdict.ok     = 1'b1;
            verdict.wel_nx = 1'b0;
         end
         K_WRSR: begin
            if (!wel) begin
               verdict.nok = 1'b1;
            end else if (locked) begin
               verdict.nok    = 1'b1;
               verdict.wel_nx = 1'b0;
            end else begin
               verdict.ok      = 1'b1;
               verdict.sr_load = 1'b1;
               verdict.wel_nx  = 1'b0;
            end
         end
         K_PROG, K_SERA: begin
            if (!wel) begin
               verdict.nok = 1'b1;
            end else begin
               verdict.ok     = !in_area;
               verdict.nok    = in_area;
               verdict.wel_nx = 1'b0;
            end
         end
         K_BERA: begin
            if (!wel) begin
               verdict.nok = 1'b1;
            end else begin
               verdict.ok     = !bp_any;
               verdict.nok    = bp_any;
               verdict.wel_nx = 1'b0;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/flash_wprot.sv
module flash_wprot
   import wpg_pkg::*;
#(
   parameter int ADDR_W      = 23,
   parameter int SECT_W      = 7,
   parameter int BP_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_pin,
   input  logic              stb_wren,
   input  logic              stb_wrdi,
   input  logic              stb_wrsr,
   input  logic              stb_prog,
   input  logic              stb_serase,
   input  logic              stb_berase,
   input  logic [SR_W-1:0]   wrsr_byte,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_ok,
   output logic              cmd_nok,
   output logic [SR_W-1:0]   status_q,
   output logic              hw_locked
);

   generate
      if (SR_BP_LO + BP_W > SR_LOCK) begin : g_bad_layout
         $error("flash_wprot: protect field overlaps the lock bit");
      end
   endgenerate

   logic            wp_s;
   logic            lock_q;
   logic [BP_W-1:0] bp_q;
   logic            wel_q;
   logic            ok_q, nok_q;
   logic            bp_any, in_area;
   cmd_kind_t       kind;
   verdict_t        verdict;

   wpg_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (wp_pin),
      .pin_sync  (wp_s)
   );

   wpg_area_check #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BP_W(BP_W)) u_area (
      .bp      (bp_q),
      .addr    (cmd_addr),
      .bp_any  (bp_any),
      .in_area (in_area)
   );

   always_comb begin
      if      (stb_wren)   kind = K_WREN;
      else if (stb_wrdi)   kind = K_WRDI;
      else if (stb_wrsr)   kind = K_WRSR;
      else if (stb_prog)   kind = K_PROG;
      else if (stb_serase) kind = K_SERA;
      else if (stb_berase) kind = K_BERA;
      else                 kind = K_NONE;
   end

   assign hw_locked = lock_q & ~wp_s;

   wpg_judge u_judge (
      .kind    (kind),
      .wel     (wel_q),
      .locked  (hw_locked),
      .in_area (in_area),
      .bp_any  (bp_any),
      .verdict (verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         bp_q   <= '0;
         wel_q  <= 1'b0;
         ok_q   <= 1'b0;
         nok_q  <= 1'b0;
      end else begin
         wel_q <= verdict.wel_nx;
         ok_q  <= verdict.ok;
         nok_q <= verdict.nok;
         if (verdict.sr_load) begin
            lock_q <= wrsr_byte[SR_LOCK];
            bp_q   <= wrsr_byte[SR_BP_LO +: BP_W];
         end
      end
   end

   logic unused_byte;
   assign unused_byte = ^{wrsr_byte[SR_LOCK-1:SR_BP_LO+BP_W], wrsr_byte[SR_BP_LO-1:0]};

   always_comb begin
      status_q                     = '0;
      status_q[SR_LOCK]            = lock_q;
      status_q[SR_BP_LO +: BP_W]   = bp_q;
      status_q[SR_WEL]             = wel_q;
   end

   assign cmd_ok  = ok_q;
   assign cmd_nok = nok_q;

   logic needs_wel;
   assign needs_wel = (kind == K_WRSR) || (kind == K_PROG) ||
                      (kind == K_SERA) || (kind == K_BERA);

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_ok && cmd_nok));

   a_r11_answer: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != K_NONE) |=> (cmd_ok || cmd_nok));

   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_NONE) |=> !(cmd_ok || cmd_nok));

   a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_WREN) |=> (status_q[SR_WEL] && cmd_ok));

   a_r7_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (needs_wel && !wel_q) |=> (cmd_nok && $stable(status_q)));

   a_r5_locked_sr: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_WRSR && hw_locked) |=>
         (cmd_nok && $stable(lock_q) && $stable(bp_q) && !wel_q));

   a_r8_area_reject: assert property (@(posedge clk) disable iff (!rst_n)
      ((kind == K_PROG || kind == K_SERA) && in_area) |=> (cmd_nok && !wel_q));

   a_r10_bulk_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_BERA && bp_q != '0) |=> cmd_nok);

   a_r3_change_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(lock_q) || !$stable(bp_q)) |-> cmd_ok);

endmodule

// File: tb/tb_flash_wprot.sv
module tb_flash_wprot;

   localparam int ADDR_W = 23;
   localparam int SECT_W = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wp_pin = 1'b1;
   logic stb_wren = 0, stb_wrdi = 0, stb_wrsr = 0;
   logic stb_prog = 0, stb_serase = 0, stb_berase = 0;
   logic [7:0] wrsr_byte = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic cmd_ok, cmd_nok, hw_locked;
   logic [7:0] status_q;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   flash_wprot dut (
      .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin),
      .stb_wren(stb_wren), .stb_wrdi(stb_wrdi), .stb_wrsr(stb_wrsr),
      .stb_prog(stb_prog), .stb_serase(stb_serase), .stb_berase(stb_berase),
      .wrsr_byte(wrsr_byte), .cmd_addr(cmd_addr),
      .cmd_ok(cmd_ok), .cmd_nok(cmd_nok),
      .status_q(status_q), .hw_locked(hw_locked)
   );

   // command codes used by the bench only
   localparam int C_WREN = 0, C_WRDI = 1, C_WRSR = 2, C_PROG = 3, C_SERA = 4, C_BERA = 5;

   // model state
   bit m_lock = 0, m_wel = 0, m_pin = 1;
   int m_bp = 0;

   function automatic logic [7:0] exp_status();
      return {m_lock, 2'b00, 3'(m_bp), m_wel, 1'b0};
   endfunction

   function automatic bit exp_prot(int bp, int sect);
      return (bp != 0) && (sect >= 128 - (1 << (bp - 1)));
   endfunction

   function automatic logic [ADDR_W-1:0] sect_addr(int s, int off);
      return (ADDR_W'(s) << (ADDR_W - SECT_W)) | ADDR_W'(off);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one strobe for a cycle, sample the answer at the next falling edge
   task automatic send(int c, logic [7:0] d, logic [ADDR_W-1:0] a,
                       output logic ok, output logic nok);
      @(negedge clk);
      wrsr_byte = d;
      cmd_addr  = a;
      stb_wren   = (c == C_WREN);
      stb_wrdi   = (c == C_WRDI);
      stb_wrsr   = (c == C_WRSR);
      stb_prog   = (c == C_PROG);
      stb_serase = (c == C_SERA);
      stb_berase = (c == C_BERA);
      @(negedge clk);
      ok  = cmd_ok;
      nok = cmd_nok;
      {stb_wren, stb_wrdi, stb_wrsr, stb_prog, stb_serase, stb_berase} = '0;
   endtask

   // reference decision, then check answer and status
   task automatic do_cmd(string req, int c, logic [7:0] d, int sect);
      logic ok, nok;
      bit e_ok;
      bit locked = m_lock && !m_pin;
      case (c)
         C_WREN: begin e_ok = 1; m_wel = 1; end
         C_WRDI: begin e_ok = 1; m_wel = 0; end
         C_WRSR: begin
            e_ok = m_wel && !locked;
            if (e_ok) begin m_lock = d[7]; m_bp = int'(d[4:2]); end
            m_wel = 0;
         end
         C_PROG, C_SERA: begin
            e_ok = m_wel && !exp_prot(m_bp, sect);
            m_wel = 0;
         end
         default: begin
            e_ok = m_wel && (m_bp == 0);
            m_wel = 0;
         end
      endcase
      send(c, d, sect_addr(sect, 16'h1234), ok, nok);
      check({req, " ok"},  32'(ok),  32'(e_ok));
      check({req, " nok"}, 32'(nok), 32'(!e_ok));
      check({req, " status"}, 32'(status_q), 32'(exp_status()));
   endtask

   task automatic set_pin(bit v);
      @(negedge clk);
      wp_pin = v;
      m_pin  = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 status", 32'(status_q), 32'h0);
      check("R1 hw_locked", 32'(hw_locked), 32'h0);
      check("R1 pulses", 32'({cmd_ok, cmd_nok}), 32'h0);
   endtask

   task automatic t_latch();
      do_cmd("R2 wren", C_WREN, 8'h00, 0);
      do_cmd("R2 wrdi", C_WRDI, 8'h00, 0);
      @(negedge clk);
      check("R11 quiet", 32'({cmd_ok, cmd_nok}), 32'h0);
   endtask

   task automatic t_no_latch();
      do_cmd("R7 wrsr", C_WRSR, 8'h9C, 0);
      do_cmd("R7 prog", C_PROG, 8'h00, 3);
      do_cmd("R7 serase", C_SERA, 8'h00, 3);
      do_cmd("R7 berase", C_BERA, 8'h00, 3);
   endtask

   task automatic t_free_write();
      set_pin(0);
      do_cmd("R3 wren", C_WREN, 8'h00, 0);
      do_cmd("R3 wrsr pin low", C_WRSR, 8'h0C, 0);
      check("R6 unlocked bp only", 32'(hw_locked), 32'h0);
      set_pin(1);
      do_cmd("R3 wren", C_WREN, 8'h00, 0);
      do_cmd("R3 wrsr pin high", C_WRSR, 8'h00, 0);
   endtask

   task automatic t_lock_order_a();
      // lock bit first, then pin low
      do_cmd("R4 wren", C_WREN, 8'h00, 0);
      do_cmd("R4 wrsr set lock", C_WRSR, 8'h84, 0);
      check("R6 pin high no lock", 32'(hw_locked), 32'h0);
      set_pin(0);
      check("R6 order a", 32'(hw_locked), 32'h1);
      do_cmd("R5 wren", C_WREN, 8'h00, 0);
      do_cmd("R5 wrsr locked", C_WRSR, 8'h00, 0);
      check("R5 lock kept", 32'(status_q), 32'h84);
      set_pin(1);
      check("R6 release", 32'(hw_locked), 32'h0);
      do_cmd("R4 wren", C_WREN, 8'h00, 0);
      do_cmd("R4 wrsr clear", C_WRSR, 8'h00, 0);
   endtask

   task automatic t_lock_order_b();
      // pin low first, then lock bit
      set_pin(0);
      check("R6 pin only", 32'(hw_locked), 32'h0);
      do_cmd("R3 wren", C_WREN, 8'h00, 0);
      do_cmd("R3 wrsr set lock", C_WRSR, 8'h88, 0);
      check("R6 order b", 32'(hw_locked), 32'h1);
      do_cmd("R5 wren", C_WREN, 8'h00, 0);
      do_cmd("R5 wrsr locked b", C_WRSR, 8'h00, 0);
      do_cmd("R8 wren", C_WREN, 8'h00, 0);
      do_cmd("R8 prog locked area", C_PROG, 8'h00, 127);
      do_cmd("R9 wren", C_WREN, 8'h00, 0);
      do_cmd("R9 prog locked open", C_PROG, 8'h00, 10);
      set_pin(1);
      do_cmd("R4 wren", C_WREN, 8'h00, 0);
      do_cmd("R4 wrsr unlock", C_WRSR, 8'h00, 0);
   endtask

   task automatic t_areas();
      for (int bp = 1; bp < 8; bp++) begin
         int edge_s = 128 - (1 << (bp - 1));
         do_cmd("R3 wren", C_WREN, 8'h00, 0);
         do_cmd("R3 wrsr bp", C_WRSR, 8'(bp << 2), 0);
         do_cmd("R8 wren", C_WREN, 8'h00, 0);
         do_cmd("R8 prog edge", C_PROG, 8'h00, edge_s);
         do_cmd("R8 wren", C_WREN, 8'h00, 0);
         do_cmd("R8 serase top", C_SERA, 8'h00, 127);
         do_cmd("R9 wren", C_WREN, 8'h00, 0);
         do_cmd("R9 serase below", C_SERA, 8'h00, edge_s - 1);
         do_cmd("R10 wren", C_WREN, 8'h00, 0);
         do_cmd("R10 berase bp set", C_BERA, 8'h00, 0);
      end
      do_cmd("R3 wren", C_WREN, 8'h00, 0);
      do_cmd("R3 wrsr bp0", C_WRSR, 8'h00, 0);
      do_cmd("R9 wren", C_WREN, 8'h00, 0);
      do_cmd("R9 prog bp0 top", C_PROG, 8'h00, 127);
      do_cmd("R10 wren", C_WREN, 8'h00, 0);
      do_cmd("R10 berase bp0", C_BERA, 8'h00, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latch();
      t_no_latch();
      t_free_write();
      t_lock_order_a();
      t_lock_order_b();
      t_areas();
      repeat (2) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule